// File: doc/BRIEF.md
# Conversion Launch and Trigger Controller

This block decides when a filter channel begins a conversion. Two kinds of conversion are handled. A regular conversion is launched either by a software start bit in the control word or, in lockstep mode, by the start pulse of the master filter instance. It runs either once or continuously. An injected conversion is launched by an edge on one of eight external trigger inputs. The trigger input is picked by a select field and the qualifying edge by a mode field.

Software writes a single control word through a write strobe and reads it back on a parallel readback bus. A global filter-enable input gates all launching activity. The lockstep, edge, select and DMA-enable fields are frozen while the filter is enabled. The block emits one-cycle start pulses for both kinds of conversion and a regular-busy flag. It consumes a conversion-done pulse from the filter datapath.

Top module: `conv_launch_ctrl`

## Requirements
- R1: After a synchronous active-low reset, `reg_start`, `inj_start`, `reg_busy` and every bit of `cfg_rd` are 0.
- R2: A write with bit 0 set, while `filt_en`=1, `reg_busy`=0 and the lockstep bit (bit 2) is 0, makes `reg_start` high for exactly the one cycle after the write edge. `reg_busy` becomes 1 in that same cycle. Bit 0 always reads back as 0.
- R3: A write with bit 0 set has no effect while `reg_busy`=1, and has no effect while the lockstep bit is 1.
- R4: With the lockstep bit at 1 and `filt_en`=1, a `master_start` pulse gives `reg_start` in the next cycle and sets `reg_busy`. With the lockstep bit at 0, `master_start` is ignored.
- R5: With the continuous bit (bit 1) at 0, a `conv_done` pulse while busy clears `reg_busy` on the next cycle and no further `reg_start` is produced.
- R6: With the continuous bit at 1, a `conv_done` pulse while busy gives a new `reg_start` in the next cycle, and `reg_busy` stays 1.
- R7: A write that clears the continuous bit in the same cycle as `conv_done` stops continuous operation at once: no restart, and `reg_busy` clears.
- R8: The edge field (bits 5:4) selects 00 = off, 01 = rising, 10 = falling, 11 = both. A qualifying change of the selected trigger that is first sampled at edge k gives a one-cycle `inj_start` in the cycle after edge k+1.
- R9: The select field (bits 8:6) chooses which `trig_in` bit is watched. Edges on the other inputs produce no `inj_start`.
- R10: While `filt_en`=1, writes leave bits 2, 3, 5:4 and 8:6 unchanged. The continuous bit stays writable at all times. While `filt_en`=0, all fields are writable.
- R11: While `filt_en`=0, `reg_busy` is cleared, pending starts are dropped, and neither start output pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| filt_en | input | 1 | Global filter enable |
| wr_en | input | 1 | Control word write strobe |
| wr_data | input | 9 | Control word: start, continuous, lockstep, DMA enable, edge, select |
| cfg_rd | output | 9 | Control word readback; start bit reads 0 |
| master_start | input | 1 | Regular start pulse of the master instance |
| conv_done | input | 1 | Conversion finished pulse from the datapath |
| trig_in | input | 8 | Asynchronous injected trigger inputs |
| reg_start | output | 1 | One-cycle regular conversion start |
| inj_start | output | 1 | One-cycle injected conversion start |
| reg_busy | output | 1 | Regular conversion in progress |

## Verification
Two functions of the block can land in the same cycle. The end-of-conversion handling can coincide with a control write that clears the continuous bit. A software start can also arrive on the very cycle a conversion completes. The bench provokes the first case by raising `conv_done` together with a write of the continuous bit at 0. It judges the result by the absence of any restart pulse in the scoreboard and by `reg_busy` reading 0 one cycle later. For the second case, the start request must be dropped because the block is still busy when the write is seen.

// File: rtl/conv_launch_pkg.sv
// Shared types and control word layout for the conversion launch controller.
// Assumes the select field sits above the edge field and grows with the trigger count.
package conv_launch_pkg;
    typedef enum logic [1:0] {
        EDGE_OFF  = 2'b00,
        EDGE_RISE = 2'b01,
        EDGE_FALL = 2'b10,
        EDGE_BOTH = 2'b11
    } edge_mode_e;

    localparam int BIT_START = 0;
    localparam int BIT_CONT  = 1;
    localparam int BIT_SYNC  = 2;
    localparam int BIT_DMA   = 3;
    localparam int EDGE_LSB  = 4;
    localparam int SEL_LSB   = 6;
endpackage

// File: rtl/conv_cfg_regs.sv
// Control register for the launch controller.
// The continuous bit is writable at any time. The lockstep, DMA, edge and select
// fields are writable only while the filter is disabled. The start bit is not
// stored: it is always read back as 0. Assumes wr_data is synchronous to clk.
module conv_cfg_regs
    import conv_launch_pkg::*;
#(
    parameter int SEL_W  = 3,
    localparam int WORD_W = SEL_LSB + SEL_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              filt_en,
    input  logic              wr_en,
    input  logic [WORD_W-1:0] wr_data,
    output logic              cont_q,
    output logic              cont_eff,
    output logic              sync_q,
    output edge_mode_e        edge_q,
    output logic [SEL_W-1:0]  sel_q,
    output logic [WORD_W-1:0] cfg_rd
);
    logic dma_q;

    // Continuous bit: free to change, so a clear can stop a running sequence.
    always_ff @(posedge clk) begin
        if (!rst_n)     cont_q <= 1'b0;
        else if (wr_en) cont_q <= wr_data[BIT_CONT];
    end

    // Locked fields: accept writes only while the filter is disabled.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q <= 1'b0;
            dma_q  <= 1'b0;
            edge_q <= EDGE_OFF;
            sel_q  <= '0;
        end else if (wr_en && !filt_en) begin
            sync_q <= wr_data[BIT_SYNC];
            dma_q  <= wr_data[BIT_DMA];
            edge_q <= edge_mode_e'(wr_data[EDGE_LSB +: 2]);
            sel_q  <= wr_data[SEL_LSB +: SEL_W];
        end
    end

    // Continuous value seen by this cycle's done event; a same-cycle write wins.
    always_comb cont_eff = wr_en ? wr_data[BIT_CONT] : cont_q;

    // Readback word; the start position is always zero.
    always_comb begin
        cfg_rd                      = '0;
        cfg_rd[BIT_CONT]            = cont_q;
        cfg_rd[BIT_SYNC]            = sync_q;
        cfg_rd[BIT_DMA]             = dma_q;
        cfg_rd[EDGE_LSB +: 2]       = edge_q;
        cfg_rd[SEL_LSB +: SEL_W]    = sel_q;
    end

    a_r10_locked_fields: assert property (@(posedge clk) disable iff (!rst_n)
        filt_en |=> $stable({sync_q, dma_q, edge_q, sel_q}));

    a_r2_start_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_rd[BIT_START] == 1'b0);
endmodule

// File: rtl/inj_trig_detect.sv
// Injected trigger path: selects one trigger input, passes it through a two-flop
// synchronizer and finds edges against the value one cycle older.
// Assumes the select field is stable while the filter is enabled.
module inj_trig_detect
    import conv_launch_pkg::*;
#(
    parameter int NUM_TRIG = 8,
    localparam int SEL_W   = $clog2(NUM_TRIG)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                filt_en,
    input  logic [NUM_TRIG-1:0] trig_in,
    input  logic [SEL_W-1:0]    sel,
    input  edge_mode_e          edge_mode,
    output logic                inj_start
);
    logic meta_q, sync_q, prev_q;
    logic rise, fall;

    // Synchronizer plus one history stage for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= 1'b0;
            sync_q <= 1'b0;
            prev_q <= 1'b0;
        end else begin
            meta_q <= trig_in[sel];
            sync_q <= meta_q;
            prev_q <= sync_q;
        end
    end

    // Edge qualification by the programmed mode, gated by the filter enable.
    always_comb begin
        rise = sync_q && !prev_q;
        fall = !sync_q && prev_q;
        unique case (edge_mode)
            EDGE_OFF:  inj_start = 1'b0;
            EDGE_RISE: inj_start = filt_en && rise;
            EDGE_FALL: inj_start = filt_en && fall;
            EDGE_BOTH: inj_start = filt_en && (rise || fall);
        endcase
    end

    a_r8_single_rise: assert property (@(posedge clk) disable iff (!rst_n)
        (inj_start && edge_mode == EDGE_RISE) |=> !inj_start);

    a_r11_no_inj_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        !filt_en |-> !inj_start);
endmodule

// File: rtl/reg_conv_seq.sv
// Regular conversion sequencer: accepts a software start or a lockstep start,
// tracks the busy flag and restarts on completion in continuous mode.
// Assumes conv_done is a single-cycle pulse from the filter datapath.
module reg_conv_seq (
    input  logic clk,
    input  logic rst_n,
    input  logic filt_en,
    input  logic sw_req,
    input  logic sync_q,
    input  logic master_start,
    input  logic conv_done,
    input  logic cont_eff,
    output logic reg_start,
    output logic reg_busy
);
    logic sw_go, sync_go, again, finish;

    // Launch and completion events of this cycle.
    always_comb begin
        sw_go   = sw_req && filt_en && !reg_busy && !sync_q;
        sync_go = master_start && filt_en && sync_q;
        again   = reg_busy && conv_done && cont_eff;
        finish  = reg_busy && conv_done && !cont_eff;
    end

    // Start pulse and busy flag; disabling the filter drops everything.
    always_ff @(posedge clk) begin
        if (!rst_n || !filt_en) begin
            reg_start <= 1'b0;
            reg_busy  <= 1'b0;
        end else begin
            reg_start <= sw_go || sync_go || again;
            if (sw_go || sync_go) reg_busy <= 1'b1;
            else if (finish)      reg_busy <= 1'b0;
        end
    end

    a_r2_start_sets_busy: assert property (@(posedge clk) disable iff (!rst_n)
        reg_start |-> reg_busy);

    a_r3_busy_blocks_sw: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_req && reg_busy && !conv_done && !(master_start && sync_q)) |=> !reg_start);

    a_r6_cont_restart: assert property (@(posedge clk) disable iff (!rst_n)
        (filt_en && reg_busy && conv_done && cont_eff) |=> (reg_start && reg_busy));

    a_r7_stop_now: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_busy && conv_done && !cont_eff && !(master_start && sync_q)) |=> (!reg_start && !reg_busy));

    a_r11_disable_clears: assert property (@(posedge clk) disable iff (!rst_n)
        !filt_en |=> (!reg_busy && !reg_start));
endmodule

// File: rtl/conv_launch_ctrl.sv
// Top of the conversion launch controller: control register, regular sequencer
// and injected trigger detector. Assumes all inputs except trig_in are
// synchronous to clk.
module conv_launch_ctrl
    import conv_launch_pkg::*;
#(
    parameter int NUM_TRIG = 8,
    localparam int SEL_W   = $clog2(NUM_TRIG),
    localparam int WORD_W  = SEL_LSB + SEL_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                filt_en,
    input  logic                wr_en,
    input  logic [WORD_W-1:0]   wr_data,
    output logic [WORD_W-1:0]   cfg_rd,
    input  logic                master_start,
    input  logic                conv_done,
    input  logic [NUM_TRIG-1:0] trig_in,
    output logic                reg_start,
    output logic                inj_start,
    output logic                reg_busy
);
    logic             cont_q, cont_eff, sync_q;
    edge_mode_e       edge_q;
    logic [SEL_W-1:0] sel_q;
    logic             sw_req;

    // Software start request is the strobed start bit.
    always_comb sw_req = wr_en && wr_data[BIT_START];

    conv_cfg_regs #(.SEL_W(SEL_W)) u_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .filt_en  (filt_en),
        .wr_en    (wr_en),
        .wr_data  (wr_data),
        .cont_q   (cont_q),
        .cont_eff (cont_eff),
        .sync_q   (sync_q),
        .edge_q   (edge_q),
        .sel_q    (sel_q),
        .cfg_rd   (cfg_rd)
    );

    reg_conv_seq u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .filt_en      (filt_en),
        .sw_req       (sw_req),
        .sync_q       (sync_q),
        .master_start (master_start),
        .conv_done    (conv_done),
        .cont_eff     (cont_eff),
        .reg_start    (reg_start),
        .reg_busy     (reg_busy)
    );

    inj_trig_detect #(.NUM_TRIG(NUM_TRIG)) u_trig (
        .clk       (clk),
        .rst_n     (rst_n),
        .filt_en   (filt_en),
        .trig_in   (trig_in),
        .sel       (sel_q),
        .edge_mode (edge_q),
        .inj_start (inj_start)
    );

    a_r4_master_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (master_start && !sync_q && !wr_en && !conv_done) |=> !reg_start);

    a_r5_single_done: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_busy && conv_done && !cont_q && !wr_en && !master_start) |=> !reg_busy);
endmodule

// File: tb/conv_launch_ctrl_tb.sv
// Scoreboard bench: driver tasks push the expected start-pulse cycles into
// queues, and a monitor pops and compares them as pulses appear.
module conv_launch_ctrl_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       filt_en = 1'b0;
    logic       wr_en = 1'b0;
    logic [8:0] wr_data = '0;
    logic [8:0] cfg_rd;
    logic       master_start = 1'b0;
    logic       conv_done = 1'b0;
    logic [7:0] trig_in = '0;
    logic       reg_start, inj_start, reg_busy;

    int n_vec = 0;
    int n_bad = 0;
    int cyc = 0;
    bit finished = 0;
    int    reg_q[$];
    string reg_r[$];
    int    inj_q[$];
    string inj_r[$];

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    conv_launch_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .filt_en(filt_en), .wr_en(wr_en),
        .wr_data(wr_data), .cfg_rd(cfg_rd), .master_start(master_start),
        .conv_done(conv_done), .trig_in(trig_in), .reg_start(reg_start),
        .inj_start(inj_start), .reg_busy(reg_busy)
    );

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    // Inputs set in the current cycle give a regular pulse one cycle later.
    task automatic exp_reg(string req);
        reg_q.push_back(cyc + 1);
        reg_r.push_back(req);
    endtask

    // A trigger change driven now gives an injected pulse two cycles later.
    task automatic exp_inj(string req);
        inj_q.push_back(cyc + 2);
        inj_r.push_back(req);
    endtask

    task automatic wr(logic [8:0] d, bit starts, string req);
        wr_en = 1'b1;
        wr_data = d;
        if (starts) exp_reg(req);
        tick();
        wr_en = 1'b0;
    endtask

    task automatic done_pulse(bit restarts, string req);
        conv_done = 1'b1;
        if (restarts) exp_reg(req);
        tick();
        conv_done = 1'b0;
    endtask

    task automatic trig(int idx, logic v, bit fires, string req);
        trig_in[idx] = v;
        if (fires) exp_inj(req);
        repeat (4) tick();
    endtask

    // Monitor: compare observed start pulses with the scoreboard queues.
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            if (reg_start) begin
                n_vec++;
                if (reg_q.size() == 0 || reg_q[0] != cyc) begin
                    n_bad++;
                    $display("FAIL R3 R11 unexpected reg_start at %0d actual=1 expected=0", cyc);
                end else begin
                    void'(reg_q.pop_front());
                    void'(reg_r.pop_front());
                end
            end else if (reg_q.size() != 0 && reg_q[0] <= cyc) begin
                n_vec++; n_bad++;
                $display("FAIL %s missing reg_start at %0d actual=0 expected=1", reg_r[0], cyc);
                void'(reg_q.pop_front());
                void'(reg_r.pop_front());
            end
            if (inj_start) begin
                n_vec++;
                if (inj_q.size() == 0 || inj_q[0] != cyc) begin
                    n_bad++;
                    $display("FAIL R9 R11 unexpected inj_start at %0d actual=1 expected=0", cyc);
                end else begin
                    void'(inj_q.pop_front());
                    void'(inj_r.pop_front());
                end
            end else if (inj_q.size() != 0 && inj_q[0] <= cyc) begin
                n_vec++; n_bad++;
                $display("FAIL %s missing inj_start at %0d actual=0 expected=1", inj_r[0], cyc);
                void'(inj_q.pop_front());
                void'(inj_r.pop_front());
            end
        end
    end

    initial begin
        #(4 * 20000);
        if (!finished) begin
            finished = 1;
            n_vec++; n_bad++;
            $display("FAIL watchdog actual=timeout expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        // R1: reset state
        chk("R1 reg_start", reg_start, 0);
        chk("R1 inj_start", inj_start, 0);
        chk("R1 reg_busy", reg_busy, 0);
        chk("R1 cfg_rd", cfg_rd, 0);

        // Disabled filter: fields writable, start ignored (R10, R11, R2)
        wr(9'h090, 0, "R10");
        chk("R10 write while disabled", cfg_rd, 9'h090);
        wr(9'h091, 0, "R11");
        chk("R11 no busy while disabled", reg_busy, 0);
        chk("R2 start bit reads zero", cfg_rd, 9'h090);

        filt_en = 1'b1;
        tick();
        // R4: master start ignored when lockstep is off
        master_start = 1'b1; tick(); master_start = 1'b0; tick();
        chk("R4 master ignored", reg_busy, 0);
        // R2: software start
        wr(9'h091, 1, "R2");
        chk("R2 busy set", reg_busy, 1);
        // R3: start while busy is ignored
        wr(9'h091, 0, "R3");
        tick();
        // R5: single mode completion, start in the done cycle is dropped
        wr_en = 1'b1; wr_data = 9'h091;
        done_pulse(0, "R5");
        wr_en = 1'b0;
        chk("R5 busy cleared", reg_busy, 0);
        tick();

        // R6: continuous restart
        wr(9'h093, 1, "R6");
        tick();
        done_pulse(1, "R6");
        chk("R6 busy kept", reg_busy, 1);
        tick();
        // R7: clearing continuous together with done stops at once
        wr_en = 1'b1; wr_data = 9'h090;
        done_pulse(0, "R7");
        wr_en = 1'b0;
        chk("R7 busy cleared", reg_busy, 0);

        // R10: locked fields ignore writes while enabled, continuous does not
        wr(9'h036, 0, "R10");
        chk("R10 locked fields", cfg_rd, 9'h092);
        wr(9'h090, 0, "R10");
        chk("R10 continuous cleared", cfg_rd, 9'h090);

        // R8 rising on input 2; R9 other inputs ignored
        trig(2, 1, 1, "R8 rise");
        trig(2, 0, 0, "R8 rise");
        trig(5, 1, 0, "R9");
        trig(5, 0, 0, "R9");

        // R8 falling on input 5 (R9 select)
        filt_en = 1'b0; wr(9'h160, 0, "R8"); filt_en = 1'b1; tick();
        trig(5, 1, 0, "R8 fall");
        trig(5, 0, 1, "R8 fall");
        // R8 both edges
        filt_en = 1'b0; wr(9'h170, 0, "R8"); filt_en = 1'b1; tick();
        trig(5, 1, 1, "R8 both");
        trig(5, 0, 1, "R8 both");
        // R8 off
        filt_en = 1'b0; wr(9'h140, 0, "R8"); filt_en = 1'b1; tick();
        trig(5, 1, 0, "R8 off");
        trig(5, 0, 0, "R8 off");

        // R4: lockstep start; R3: software start ignored in lockstep
        filt_en = 1'b0; wr(9'h034, 0, "R4"); filt_en = 1'b1; tick();
        chk("R4 lockstep field", cfg_rd, 9'h034);
        wr(9'h035, 0, "R3");
        chk("R3 lockstep blocks software", reg_busy, 0);
        master_start = 1'b1; exp_reg("R4"); tick(); master_start = 1'b0;
        chk("R4 busy set", reg_busy, 1);

        // R11: disabling clears busy and blocks triggers
        filt_en = 1'b0;
        tick();
        chk("R11 busy cleared", reg_busy, 0);
        trig(0, 1, 0, "R11");
        trig(0, 0, 0, "R11");
        master_start = 1'b1; tick(); master_start = 1'b0;
        repeat (4) tick();
        chk("R11 still idle", reg_busy, 0);
        chk("R2 R4 R6 R8 scoreboard drained", reg_q.size() + inj_q.size(), 0);

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule